// File: doc/BRIEF.md
# Priority Crossbar Pin Assigner

This block hands a fixed set of internal peripheral signals out to a bank of general-purpose port pins. The signals are grouped by peripheral and ranked in a fixed order. Each enabled signal, taken in rank order, gets the lowest-numbered routable pin that is still free. A pin is free when no earlier signal has taken it, its skip bit is clear, and it is not set to analog. Only the lowest `NUM_ROUTED` pins can carry peripheral signals. Every other pin, and every routable pin left over, works as a plain GPIO driven from its latch bit.

The pin map is held in a register. It is rebuilt on every clock edge from the current enables, the skip bits and the analog bits. A configuration change therefore shows at the pins one cycle later. The data path is combinational from the registered map: peripheral output values, output enables, output-mode bits, latch values and pad inputs reach the pad drivers and `periph_in` in the same cycle. `port_read` always shows the raw pad levels. All ports are plain control and data levels with no handshake, because every output follows its inputs on every cycle.

Signal index order, highest priority first:

| Index | Signal |
|---|---|
| 0–1 | serial port |
| 2–5 | SPI |
| 6–7 | two-wire bus |
| 8–9 | comparator 0 |
| 10–11 | comparator 1 |
| 12 | clock out |
| 13–18 | capture channels 0–5 |
| 19 | timer 0 input |
| 20 | timer 1 input |

Top module: `pin_xbar`

## Requirements
- R1: Requested signals are served in ascending signal index: serial port 0–1, SPI 2–5, two-wire bus 6–7, comparator 0 8–9, comparator 1 10–11, clock out 12, capture channels 13–18, timer 0 19, timer 1 20. Enable `en_uart` requests 0–1, `en_spi` 2–5, `en_smbus` 6–7, `en_cmp0` 8–9, `en_cmp1` 10–11, `en_clkout` 12, `en_t0` 19, `en_t1` 20.
- R2: Each requested signal takes the lowest-numbered eligible pin that no earlier signal holds. Only pins 0 to `NUM_ROUTED`-1 (default 20) are ever assigned. No pin carries two signals, and no signal reaches two pins.
- R3: A routable pin whose `pin_skip` bit is 1 is never assigned, and its drive enable is 0.
- R4: A pin whose `pin_analog` bit is 1 is never assigned, and its drive enable is 0. This applies to every pin, routable or not.
- R5: `pca_chans` = n requests capture channels 0 to n-1. A value above 6 acts as 6.
- R6: A requested signal that finds no eligible pin is left unconnected, and its `periph_in` bit reads 1. A signal that is not requested also reads 1.
- R7: On an assigned pin, the output value and output enable come from that signal's `periph_out` and `periph_oe` bits. The signal's `periph_in` bit equals that pin's `pin_in`.
- R8: A pin that is neither assigned, skipped nor analog is a GPIO. Its output value is its `gpio_latch` bit and its output enable is 1.
- R9: With `pin_pushpull` = 1, `pin_drive` is the output value and `pin_drive_en` is the output enable. With `pin_pushpull` = 0 (open drain), `pin_drive` is 0 and `pin_drive_en` is the output enable AND NOT the output value.
- R10: `port_read` equals `pin_in` on every pin at all times, whatever the configuration.
- R11: Enables, `pca_chans`, `pin_skip` and `pin_analog` are sampled at the clock edge and take effect one cycle later. While `rst_n` is low, the map is empty and no pin is treated as skipped or analog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| en_uart | input | 1 | request serial-port signals |
| en_spi | input | 1 | request SPI signals |
| en_smbus | input | 1 | request two-wire bus signals |
| en_cmp0 | input | 1 | request comparator 0 outputs |
| en_cmp1 | input | 1 | request comparator 1 outputs |
| en_clkout | input | 1 | request clock output |
| en_t0 | input | 1 | request timer 0 input |
| en_t1 | input | 1 | request timer 1 input |
| pca_chans | input | 3 | number of capture channels requested |
| pin_skip | input | NUM_ROUTED | exclude routable pin from assignment |
| pin_analog | input | NUM_PINS | pin is analog: no assignment, no drive |
| pin_pushpull | input | NUM_PINS | 1 push-pull, 0 open drain |
| gpio_latch | input | NUM_PINS | GPIO output value |
| periph_out | input | 21 | peripheral output values by signal index |
| periph_oe | input | 21 | peripheral output enables by signal index |
| pin_in | input | NUM_PINS | pad input levels |
| pin_drive | output | NUM_PINS | pad output value |
| pin_drive_en | output | NUM_PINS | pad driver enable |
| periph_in | output | 21 | pad levels routed back to signals |
| port_read | output | NUM_PINS | raw pad levels for readback |

## Verification
Four things are checked on every cycle: no pin holds two signals and no signal holds two pins, an open-drain pin never drives high, a pin that was skipped or analog at the previous edge has its driver off, and a signal that was not requested at the previous edge reads 1. Whether each signal lands on the correct pin in rank order can only be shown by the bench scenarios, which compare all outputs against an allocation model. The same holds for capture-count clamping, overflow when pins run out, and the one-cycle configuration latency.

// File: rtl/pin_xbar_pkg.sv
package pin_xbar_pkg;
  localparam int XB_SIGS        = 21;
  localparam int XB_ROUTED_PINS = 20;
  localparam int XB_PINS        = 29;
  localparam int XB_PCA_MAX     = 6;
  localparam int XB_PCA_W       = 3;

  // signal index bases, in priority order
  localparam int SIG_UART = 0;
  localparam int SIG_SPI  = 2;
  localparam int SIG_SMB  = 6;
  localparam int SIG_CMP0 = 8;
  localparam int SIG_CMP1 = 10;
  localparam int SIG_CLKO = 12;
  localparam int SIG_PCA  = 13;
  localparam int SIG_T0   = 19;
  localparam int SIG_T1   = 20;

  typedef struct packed {
    logic                uart;
    logic                spi;
    logic                smbus;
    logic                cmp0;
    logic                cmp1;
    logic                clkout;
    logic                t0;
    logic                t1;
    logic [XB_PCA_W-1:0] pca_chans;
  } xbar_en_t;
endpackage

// File: rtl/xbar_req_decode.sv
module xbar_req_decode
  import pin_xbar_pkg::*;
(
  input  xbar_en_t             en,
  output logic [XB_SIGS-1:0]   req
);
  logic [XB_PCA_W-1:0]   pca_eff;
  logic [XB_PCA_MAX-1:0] pca_req;

  assign pca_eff = (en.pca_chans > XB_PCA_W'(XB_PCA_MAX)) ? XB_PCA_W'(XB_PCA_MAX) : en.pca_chans;

  for (genvar ch = 0; ch < XB_PCA_MAX; ch++) begin : g_pca
    assign pca_req[ch] = (pca_eff > XB_PCA_W'(ch));
  end

  always_comb begin
    req = '0;
    req[SIG_UART +: 2]         = {2{en.uart}};
    req[SIG_SPI  +: 4]         = {4{en.spi}};
    req[SIG_SMB  +: 2]         = {2{en.smbus}};
    req[SIG_CMP0 +: 2]         = {2{en.cmp0}};
    req[SIG_CMP1 +: 2]         = {2{en.cmp1}};
    req[SIG_CLKO]              = en.clkout;
    req[SIG_PCA +: XB_PCA_MAX] = pca_req;
    req[SIG_T0]                = en.t0;
    req[SIG_T1]                = en.t1;
  end
endmodule

// File: rtl/xbar_prefix_rank.sv
module xbar_prefix_rank #(
  parameter int N = 8,
  parameter int W = 4
) (
  input  logic [N-1:0]        bits,
  output logic [N-1:0][W-1:0] rank
);
  // rank[i] = number of set bits strictly below position i
  always_comb begin
    logic [W-1:0] acc;
    acc = '0;
    for (int i = 0; i < N; i++) begin
      rank[i] = acc;
      acc     = acc + W'(bits[i]);
    end
  end
endmodule

// File: rtl/xbar_alloc.sv
module xbar_alloc #(
  parameter int NSIG = 21,
  parameter int NPIN = 20,
  parameter int W    = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSIG-1:0]            req,
  input  logic [NPIN-1:0]            elig,
  output logic [NPIN-1:0][NSIG-1:0]  map_q
);
  logic [NSIG-1:0][W-1:0]   sig_rank;
  logic [NPIN-1:0][W-1:0]   pin_rank;
  logic [NPIN-1:0][NSIG-1:0] match;

  xbar_prefix_rank #(.N(NSIG), .W(W)) u_sig_rank (.bits(req),  .rank(sig_rank));
  xbar_prefix_rank #(.N(NPIN), .W(W)) u_pin_rank (.bits(elig), .rank(pin_rank));

  // signal k-th among requested meets pin k-th among eligible
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    for (genvar i = 0; i < NSIG; i++) begin : g_sig
      assign match[p][i] = req[i] & elig[p] & (sig_rank[i] == pin_rank[p]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map_q <= '0;
    else        map_q <= match;
  end
endmodule

// File: rtl/xbar_pad_cell.sv
module xbar_pad_cell (
  input  logic route_hit,
  input  logic route_val,
  input  logic route_oe,
  input  logic blocked,
  input  logic push_pull,
  input  logic latch,
  output logic drv,
  output logic drv_en
);
  logic val;
  logic want;

  always_comb begin
    if (blocked) begin
      val  = 1'b0;
      want = 1'b0;
    end else if (route_hit) begin
      val  = route_val;
      want = route_oe;
    end else begin
      val  = latch;
      want = 1'b1;
    end
    if (push_pull) begin
      drv    = val;
      drv_en = want;
    end else begin
      drv    = 1'b0;
      drv_en = want & ~val;
    end
  end
endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
  import pin_xbar_pkg::*;
#(
  parameter int NUM_PINS   = XB_PINS,
  parameter int NUM_ROUTED = XB_ROUTED_PINS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en_uart,
  input  logic                  en_spi,
  input  logic                  en_smbus,
  input  logic                  en_cmp0,
  input  logic                  en_cmp1,
  input  logic                  en_clkout,
  input  logic                  en_t0,
  input  logic                  en_t1,
  input  logic [XB_PCA_W-1:0]   pca_chans,
  input  logic [NUM_ROUTED-1:0] pin_skip,
  input  logic [NUM_PINS-1:0]   pin_analog,
  input  logic [NUM_PINS-1:0]   pin_pushpull,
  input  logic [NUM_PINS-1:0]   gpio_latch,
  input  logic [XB_SIGS-1:0]    periph_out,
  input  logic [XB_SIGS-1:0]    periph_oe,
  input  logic [NUM_PINS-1:0]   pin_in,
  output logic [NUM_PINS-1:0]   pin_drive,
  output logic [NUM_PINS-1:0]   pin_drive_en,
  output logic [XB_SIGS-1:0]    periph_in,
  output logic [NUM_PINS-1:0]   port_read
);
  localparam int RANK_MAX = (XB_SIGS > NUM_ROUTED) ? XB_SIGS : NUM_ROUTED;
  localparam int RANK_W   = $clog2(RANK_MAX + 1);

  xbar_en_t                           en;
  logic [XB_SIGS-1:0]                 sig_req;
  logic [NUM_ROUTED-1:0]              elig;
  logic [NUM_PINS-1:0]                blocked_d;
  logic [NUM_PINS-1:0]                blocked_q;
  logic [NUM_ROUTED-1:0][XB_SIGS-1:0] map_q;

  assign en = '{uart: en_uart, spi: en_spi, smbus: en_smbus, cmp0: en_cmp0,
                cmp1: en_cmp1, clkout: en_clkout, t0: en_t0, t1: en_t1,
                pca_chans: pca_chans};

  xbar_req_decode u_req (.en(en), .req(sig_req));

  assign elig = ~pin_skip & ~pin_analog[NUM_ROUTED-1:0];

  xbar_alloc #(.NSIG(XB_SIGS), .NPIN(NUM_ROUTED), .W(RANK_W)) u_alloc (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (sig_req),
    .elig  (elig),
    .map_q (map_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blocked_q <= '0;
    else        blocked_q <= blocked_d;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
    logic hit;
    logic val;
    logic oe;
    if (p < NUM_ROUTED) begin : g_routed
      assign blocked_d[p] = pin_analog[p] | pin_skip[p];
      assign hit = |map_q[p];
      assign val = |(map_q[p] & periph_out);
      assign oe  = |(map_q[p] & periph_oe);
    end else begin : g_plain
      assign blocked_d[p] = pin_analog[p];
      assign hit = 1'b0;
      assign val = 1'b0;
      assign oe  = 1'b0;
    end
    xbar_pad_cell u_cell (
      .route_hit (hit),
      .route_val (val),
      .route_oe  (oe),
      .blocked   (blocked_q[p]),
      .push_pull (pin_pushpull[p]),
      .latch     (gpio_latch[p]),
      .drv       (pin_drive[p]),
      .drv_en    (pin_drive_en[p])
    );
  end

  for (genvar i = 0; i < XB_SIGS; i++) begin : g_ret
    logic [NUM_ROUTED-1:0] col;
    for (genvar p = 0; p < NUM_ROUTED; p++) begin : g_col
      assign col[p] = map_q[p][i];
    end
    assign periph_in[i] = (|col) ? |(col & pin_in[NUM_ROUTED-1:0]) : 1'b1;
  end

  assign port_read = pin_in;
endmodule

// File: rtl/pin_xbar_chk.sv
module pin_xbar_chk #(
  parameter int NUM_PINS   = 29,
  parameter int NUM_ROUTED = 20,
  parameter int NSIG       = 21
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [NUM_ROUTED-1:0][NSIG-1:0] map_q,
  input logic [NSIG-1:0]                sig_req,
  input logic [NUM_ROUTED-1:0]          pin_skip,
  input logic [NUM_PINS-1:0]            pin_analog,
  input logic [NUM_PINS-1:0]            pin_pushpull,
  input logic [NUM_PINS-1:0]            pin_drive,
  input logic [NUM_PINS-1:0]            pin_drive_en,
  input logic [NSIG-1:0]                periph_in
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  for (genvar p = 0; p < NUM_ROUTED; p++) begin : g_pin
    p_one_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(map_q[p]));
  end

  for (genvar i = 0; i < NSIG; i++) begin : g_sig
    logic [NUM_ROUTED-1:0] col;
    for (genvar p = 0; p < NUM_ROUTED; p++) begin : g_c
      assign col[p] = map_q[p][i];
    end
    p_one_pin_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col));
  end

  p_od_never_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_drive_en & ~pin_pushpull & pin_drive) == '0);

  p_analog_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (pin_drive_en & $past(pin_analog)) == '0);

  p_skip_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (pin_drive_en[NUM_ROUTED-1:0] & $past(pin_skip)) == '0);

  p_idle_reads_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (~$past(sig_req) & ~periph_in) == '0);
endmodule

bind pin_xbar pin_xbar_chk #(
  .NUM_PINS   (NUM_PINS),
  .NUM_ROUTED (NUM_ROUTED),
  .NSIG       (pin_xbar_pkg::XB_SIGS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .map_q        (map_q),
  .sig_req      (sig_req),
  .pin_skip     (pin_skip),
  .pin_analog   (pin_analog),
  .pin_pushpull (pin_pushpull),
  .pin_drive    (pin_drive),
  .pin_drive_en (pin_drive_en),
  .periph_in    (periph_in)
);

// File: tb/pin_xbar_test.sv
module pin_xbar_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 21;
  localparam int NX = 20;
  localparam int NP = 29;
  localparam int NVEC = 10;

  // entry: {enables[7:0] = uart,spi,smb,cmp0,cmp1,clkout,t0,t1 ; pca[2:0] ; skip[19:0]}
  localparam logic [30:0] VEC [NVEC] = '{
    {8'h00, 3'd0, 20'h00000},
    {8'h80, 3'd0, 20'h00000},
    {8'hC0, 3'd0, 20'h00002},
    {8'hFF, 3'd6, 20'h00000},
    {8'h21, 3'd0, 20'h0000F},
    {8'h0C, 3'd3, 20'h55555},
    {8'hFF, 3'd6, 20'hFFFFF},
    {8'h00, 3'd7, 20'h00000},
    {8'h02, 3'd0, 20'h7FFFF},
    {8'h50, 3'd2, 20'hF0F0F}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]    b_en = '0;
  logic [2:0]    b_pca = '0;
  logic [NX-1:0] b_skip = '0;
  logic [NP-1:0] b_analog = '0;
  logic [NP-1:0] b_pp = '0;
  logic [NP-1:0] b_latch = '0;
  logic [NS-1:0] b_pout = '0;
  logic [NS-1:0] b_poe = '0;
  logic [NP-1:0] b_pin = '0;
  logic [NP-1:0] pin_drive, pin_drive_en, port_read;
  logic [NS-1:0] periph_in;

  logic [NP-1:0] exp_drive, exp_en;
  logic [NS-1:0] exp_pin;
  logic [31:0]   rng = 32'h1234_5678;
  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_xbar uut (
    .clk(clk), .rst_n(rst_n),
    .en_uart(b_en[7]), .en_spi(b_en[6]), .en_smbus(b_en[5]), .en_cmp0(b_en[4]),
    .en_cmp1(b_en[3]), .en_clkout(b_en[2]), .en_t0(b_en[1]), .en_t1(b_en[0]),
    .pca_chans(b_pca), .pin_skip(b_skip), .pin_analog(b_analog),
    .pin_pushpull(b_pp), .gpio_latch(b_latch), .periph_out(b_pout),
    .periph_oe(b_poe), .pin_in(b_pin), .pin_drive(pin_drive),
    .pin_drive_en(pin_drive_en), .periph_in(periph_in), .port_read(port_read)
  );

  function automatic logic [31:0] next_rng(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic roll();
    rng = next_rng(rng);
  endtask

  // reference allocation from the requirements
  task automatic model();
    logic [NS-1:0] req;
    int sigpin [NS];
    int owner [NP];
    int n;
    int p;
    logic val, want, blk;
    req = '0;
    if (b_en[7]) req[1:0] = '1;
    if (b_en[6]) req[5:2] = '1;
    if (b_en[5]) req[7:6] = '1;
    if (b_en[4]) req[9:8] = '1;
    if (b_en[3]) req[11:10] = '1;
    if (b_en[2]) req[12] = 1'b1;
    n = (b_pca > 3'd6) ? 6 : int'(b_pca);
    for (int c = 0; c < n; c++) req[13+c] = 1'b1;
    if (b_en[1]) req[19] = 1'b1;
    if (b_en[0]) req[20] = 1'b1;
    for (int q = 0; q < NP; q++) owner[q] = -1;
    p = 0;
    for (int i = 0; i < NS; i++) begin
      sigpin[i] = -1;
      if (req[i]) begin
        while (p < NX && (b_skip[p] || b_analog[p])) p++;
        if (p < NX) begin
          sigpin[i] = p;
          owner[p] = i;
          p++;
        end
      end
    end
    for (int q = 0; q < NP; q++) begin
      blk = b_analog[q] || (q < NX && b_skip[q]);
      if (blk) begin
        val = 1'b0; want = 1'b0;
      end else if (owner[q] >= 0) begin
        val = b_pout[owner[q]]; want = b_poe[owner[q]];
      end else begin
        val = b_latch[q]; want = 1'b1;
      end
      exp_drive[q] = b_pp[q] ? val : 1'b0;
      exp_en[q]    = b_pp[q] ? want : (want & ~val);
    end
    for (int i = 0; i < NS; i++)
      exp_pin[i] = (sigpin[i] >= 0) ? b_pin[sigpin[i]] : 1'b1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string ctx);
    model();
    check({ctx, " R7 R8 R9 pin_drive"},    32'(pin_drive),    32'(exp_drive));
    check({ctx, " R3 R4 R8 R9 drive_en"},  32'(pin_drive_en), 32'(exp_en));
    check({ctx, " R1 R2 R5 R6 R7 periph_in"}, 32'(periph_in), 32'(exp_pin));
    check({ctx, " R10 port_read"},         32'(port_read),    32'(b_pin));
  endtask

  task automatic data_pattern();
    roll(); b_pout  = rng[NS-1:0];
    roll(); b_poe   = rng[NS-1:0];
    roll(); b_pp    = rng[NP-1:0];
    roll(); b_latch = rng[NP-1:0];
    roll(); b_pin   = rng[NP-1:0];
  endtask

  task automatic run_cfg(input logic [30:0] v, input logic [NP-1:0] an, input string ctx);
    @(posedge clk); #1;
    b_en = v[30:23]; b_pca = v[22:20]; b_skip = v[19:0]; b_analog = an;
    @(posedge clk); #1;
    for (int k = 0; k < 2; k++) begin
      data_pattern();
      #1;
      compare_all(ctx);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // reset state, R11: empty map, nothing blocked even with analog/skip set
    b_en = 8'hFF; b_pca = 3'd6; b_skip = '1; b_analog = '1;
    b_pp = '1; b_latch = 29'h0ABC_1235; b_pin = 29'h1357_9BDF;
    b_pout = '1; b_poe = '1;
    #(CLK_PERIOD * 3);
    check("R11 reset drive", 32'(pin_drive), 32'(b_latch));
    check("R11 reset drive_en", 32'(pin_drive_en), 32'(29'h1FFF_FFFF));
    check("R11 reset periph_in", 32'(periph_in), 32'(21'h1F_FFFF));
    @(negedge clk);
    rst_n = 1'b1;

    // table walk
    for (int v = 0; v < NVEC; v++) run_cfg(VEC[v], '0, "table");

    // randomized settings, some with analog pins
    for (int r = 0; r < 24; r++) begin
      logic [30:0] rv;
      logic [NP-1:0] an;
      roll(); rv = rng[30:0];
      roll(); an = (r % 3 == 0) ? (rng[NP-1:0] & rng[28:0] & 29'h1FFF_FFFF) : '0;
      run_cfg(rv, an, "random");
    end

    // R4: analog pins skipped by allocation and never driven
    @(posedge clk); #1;
    b_en = 8'h80; b_pca = 0; b_skip = '0; b_analog = '0;
    b_analog[0] = 1'b1; b_analog[25] = 1'b1;
    b_pp = '1; b_latch = '1; b_pout = '1; b_poe = '1; b_pin = '0; b_pin[2] = 1'b0;
    @(posedge clk); #1;
    check("R4 analog pin0 off", 32'(pin_drive_en[0]), 32'd0);
    check("R4 analog pin25 off", 32'(pin_drive_en[25]), 32'd0);
    b_pout[1] = 1'b0; b_pin[2] = 1'b1; #1;
    check("R4 R7 serial lands on pins 1..2", 32'({pin_drive[2], pin_drive[1]}), 32'b01);
    check("R7 return from pin2", 32'(periph_in[1]), 32'd1);

    // R9: open drain on an assigned pin
    @(posedge clk); #1;
    b_analog = '0; b_pp = '0; b_pout = '0; b_pout[1] = 1'b1; b_poe = '1;
    @(posedge clk); #1;
    check("R9 od low drives", 32'({pin_drive_en[0], pin_drive[0]}), 32'b10);
    check("R9 od high releases", 32'({pin_drive_en[1], pin_drive[1]}), 32'b00);

    // R11: config change not visible until the next edge
    @(posedge clk); #1;
    b_en = 8'h00; b_pp = '1; b_latch = '0;
    @(posedge clk); #1;
    b_en = 8'h80; b_pout = '1; b_poe = '1; #1;
    check("R11 before edge still GPIO", 32'(pin_drive[1:0]), 32'b00);
    @(posedge clk); #1;
    check("R11 after edge routed", 32'(pin_drive[1:0]), 32'b11);

    // R5 clamp and R6 overflow at the ends of the pin range
    run_cfg({8'h00, 3'd7, 20'h00000}, '0, "R5 clamp");
    run_cfg({8'hFF, 3'd6, 20'h00000}, '0, "R6 overflow");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule